// File: doc/BRIEF.md
# External Interrupt Request Detector

This block watches eight external request inputs and turns them into latched request flags for an interrupt controller. A divide-by-`CYCLE_DIV` counter produces a one-clock machine-cycle strobe. Each input passes through a synchronizer and is sampled only on that strobe. The sample is compared with the one taken a machine cycle earlier. This comparison gives edge events, and the sample on its own gives a level.

The sources fall into four kinds. Sources 0 and 1 are selectable per source as low-level or falling-edge. Sources 2 and 3 are falling-edge or rising-edge according to a polarity bit. Sources 4 to 6 are rising-edge only. Source 7 is the timer reload-trigger input. It is falling-edge, and its edge counts only while its enable bit is high.

Each flag is a two-state machine per source with the states `FLAG_CLEAR` and `FLAG_SET`. There are three transitions:
- `set` is taken on a qualifying strobe.
- `kill` is taken when the controller acknowledges entry into the service routine, or when software writes a clear.
- `track` applies in level mode only: the flag follows the sampled pin on every strobe.

When a set and a kill arrive in the same cycle, the set wins.

Top module: `ext_irq_detect`

## Requirements
- R1: `strobe_o` is high for exactly one clock in every `CYCLE_DIV` clocks. The first strobe after reset release comes when `CYCLE_DIV-1` rising edges have passed.
- R2: While reset is asserted, `flag_o` is all zero and `strobe_o` is low.
- R3: For source i in 0..1 with `lvl_edge_sel_i[i]`=0 (level mode), each strobe sets `flag_o[i]` to the inverse of the sampled pin. A high pin clears it (`track`).
- R4: For source i in 0..1 with `lvl_edge_sel_i[i]`=1, a strobe whose sample is low after a previous high sample takes `set`.
- R5: For source i in 2..3, `pol_sel_i[i-2]`=0 selects falling-edge detection and `pol_sel_i[i-2]`=1 selects rising-edge detection.
- R6: Sources 4, 5 and 6 take `set` when a high sample follows a low sample.
- R7: Source 7 takes `set` on a high-to-low sample pair only if `trig_en_i` is 1 in the strobe cycle. With `trig_en_i`=0 the flag does not rise.
- R8: `ack_i[i]` high for one clock outside a strobe clears `flag_o[i]` at the next edge. An edge-mode flag stays clear until a new qualifying edge occurs.
- R9: `sw_clr_i[i]` clears the flag in the same way as `ack_i[i]`. If a set event and a clear occur in the same strobe cycle, the flag ends up set.
- R10: A pin pulse that begins and ends between two strobes is not seen. No flag rises in a clock cycle without a strobe.
- R11: The first strobe after reset only primes the sample register. It produces no edge event, whatever level the pins hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | 8 | External request inputs; bit i is source i |
| lvl_edge_sel_i | input | 2 | Sources 0..1: 0 = low level, 1 = falling edge |
| pol_sel_i | input | 2 | Sources 2..3: 0 = falling edge, 1 = rising edge |
| trig_en_i | input | 1 | Enable for the source 7 falling-edge event |
| ack_i | input | 8 | Service-routine entry per source, clears the flag |
| sw_clr_i | input | 8 | Software clear per source |
| flag_o | output | 8 | Latched request flags |
| strobe_o | output | 1 | Machine-cycle strobe |

## Verification
The checker watches several properties on every cycle:
- the strobe period, using a counter of its own;
- that no flag rises outside a strobe cycle;
- that an acknowledge or software clear outside a strobe empties the flag;
- that source 7 never rises while its enable is low;
- the all-zero reset state.

Only the bench scenarios can show that each source kind sets on the correct sample pair and polarity, and that level mode tracks the pin. They also cover set-over-clear priority, the suppression of sub-cycle pulses, and the priming strobe after reset. To do this, the bench sweeps every mode combination against a computed sample history.

// File: rtl/eird_pkg.sv
package eird_pkg;
    localparam int NUM_SRC = 8;

    typedef enum logic [1:0] {
        K_LVL_FALL,
        K_POL,
        K_RISE,
        K_FALL_GATED
    } src_kind_e;

    typedef enum logic {
        FLAG_CLEAR,
        FLAG_SET
    } flag_state_e;

    function automatic src_kind_e kind_of(input int idx);
        if (idx < 2)      return K_LVL_FALL;
        else if (idx < 4) return K_POL;
        else if (idx < 7) return K_RISE;
        else              return K_FALL_GATED;
    endfunction
endpackage

// File: rtl/eird_strobe_gen.sv
module eird_strobe_gen #(
    parameter int CYCLE_DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic strobe_o
);
    localparam int CW = (CYCLE_DIV > 2) ? $clog2(CYCLE_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLE_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    assign strobe_o = (cnt_q == LAST);
endmodule

// File: rtl/eird_sync.sv
module eird_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else begin
            chain_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/eird_flag_cell.sv
module eird_flag_cell #(
    parameter eird_pkg::src_kind_e KIND = eird_pkg::K_RISE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    input  logic pin_i,
    input  logic mode_i,
    input  logic ack_i,
    input  logic clr_i,
    output logic flag_o
);
    import eird_pkg::*;

    logic        samp_q;
    logic        primed_q;
    logic        fall_ev;
    logic        rise_ev;
    logic        set_ev;
    logic        level_mode;
    logic        kill;
    flag_state_e state_q, state_d;

    // sample register, loaded once per machine cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_q   <= 1'b0;
            primed_q <= 1'b0;
        end else if (strobe_i) begin
            samp_q   <= pin_i;
            primed_q <= 1'b1;
        end
    end

    always_comb begin
        fall_ev    = primed_q &  samp_q & ~pin_i;
        rise_ev    = primed_q & ~samp_q &  pin_i;
        level_mode = (KIND == K_LVL_FALL) && !mode_i;
        kill       = ack_i | clr_i;
        unique case (KIND)
            K_LVL_FALL:   set_ev = fall_ev;
            K_POL:        set_ev = mode_i ? rise_ev : fall_ev;
            K_RISE:       set_ev = rise_ev & mode_i;
            K_FALL_GATED: set_ev = fall_ev & mode_i;
            default:      set_ev = 1'b0;
        endcase
    end

    // next-state: set, kill, track
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR: begin
                if (level_mode) begin
                    if (strobe_i && !pin_i) state_d = FLAG_SET;
                end else if (strobe_i && set_ev) begin
                    state_d = FLAG_SET;
                end
            end
            FLAG_SET: begin
                if (level_mode) begin
                    if (strobe_i) begin
                        if (pin_i) state_d = FLAG_CLEAR;
                    end else if (kill) begin
                        state_d = FLAG_CLEAR;
                    end
                end else if (!(strobe_i && set_ev) && kill) begin
                    state_d = FLAG_CLEAR;
                end
            end
            default: state_d = FLAG_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb flag_o = (state_q == FLAG_SET);
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect #(
    parameter int CYCLE_DIV   = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] pin_i,
    input  logic [1:0] lvl_edge_sel_i,
    input  logic [1:0] pol_sel_i,
    input  logic       trig_en_i,
    input  logic [7:0] ack_i,
    input  logic [7:0] sw_clr_i,
    output logic [7:0] flag_o,
    output logic       strobe_o
);
    import eird_pkg::*;

    logic [NUM_SRC-1:0] pin_sync;
    logic [NUM_SRC-1:0] mode_bit;
    logic               strobe;

    eird_strobe_gen #(.CYCLE_DIV(CYCLE_DIV)) strobe_i (
        .clk(clk), .rst_n(rst_n), .strobe_o(strobe)
    );

    eird_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(pin_sync)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        if (kind_of(g) == K_LVL_FALL) begin : g_mode
            assign mode_bit[g] = lvl_edge_sel_i[g];
        end else if (kind_of(g) == K_POL) begin : g_mode
            assign mode_bit[g] = pol_sel_i[g-2];
        end else if (kind_of(g) == K_FALL_GATED) begin : g_mode
            assign mode_bit[g] = trig_en_i;
        end else begin : g_mode
            assign mode_bit[g] = 1'b1;
        end

        eird_flag_cell #(.KIND(kind_of(g))) cell_i (
            .clk(clk), .rst_n(rst_n), .strobe_i(strobe),
            .pin_i(pin_sync[g]), .mode_i(mode_bit[g]),
            .ack_i(ack_i[g]), .clr_i(sw_clr_i[g]), .flag_o(flag_o[g])
        );
    end

    assign strobe_o = strobe;
endmodule

// File: rtl/eird_checker.sv
module eird_checker #(
    parameter int CYCLE_DIV = 12
) (
    input logic       clk,
    input logic       rst_n,
    input logic       strobe_o,
    input logic [7:0] flag_o,
    input logic [7:0] ack_i,
    input logic [7:0] sw_clr_i,
    input logic       trig_en_i
);
    localparam int PW = $clog2(CYCLE_DIV) + 1;
    localparam logic [PW-1:0] LAST = PW'(CYCLE_DIV - 1);

    logic [PW-1:0] per_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        per_cnt <= '0;
        else if (strobe_o) per_cnt <= '0;
        else               per_cnt <= per_cnt + 1'b1;
    end

    assert_strobe_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> (per_cnt == LAST));
    assert_strobe_not_missed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (per_cnt == LAST) |-> strobe_o);

    assert_reset_clear_R2: assert property (@(posedge clk)
        !rst_n |-> (flag_o == 8'h00 && !strobe_o));

    assert_gated_no_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_en_i |=> !$rose(flag_o[7]));

    for (genvar g = 0; g < 8; g++) begin : g_chk
        assert_kill_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_i[g] || sw_clr_i[g]) && !strobe_o |=> !flag_o[g]);
        assert_no_rise_off_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !strobe_o |=> !$rose(flag_o[g]));
    end
endmodule

bind ext_irq_detect eird_checker #(.CYCLE_DIV(CYCLE_DIV)) chk_i (
    .clk(clk), .rst_n(rst_n), .strobe_o(strobe_o), .flag_o(flag_o),
    .ack_i(ack_i), .sw_clr_i(sw_clr_i), .trig_en_i(trig_en_i)
);

// File: tb/ext_irq_detect_tb_top.sv
`timescale 1ns/1ps
module ext_irq_detect_tb_top;
    localparam int DIV = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_i = 8'hFF;
    logic [1:0] lvl_edge_sel_i = 2'b11;
    logic [1:0] pol_sel_i = 2'b01;
    logic       trig_en_i = 1'b1;
    logic [7:0] ack_i = 8'h00;
    logic [7:0] sw_clr_i = 8'h00;
    logic [7:0] flag_o;
    logic       strobe_o;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [7:0] m_flag = 8'h00;
    logic [7:0] m_samp = 8'h00;
    bit         m_primed = 1'b0;

    always #5 clk = ~clk;

    ext_irq_detect #(.CYCLE_DIV(DIV), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .lvl_edge_sel_i(lvl_edge_sel_i),
        .pol_sel_i(pol_sel_i), .trig_en_i(trig_en_i), .ack_i(ack_i),
        .sw_clr_i(sw_clr_i), .flag_o(flag_o), .strobe_o(strobe_o)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input int i);
        if (i < 2)      return lvl_edge_sel_i[i] ? "R4" : "R3";
        else if (i < 4) return "R5";
        else if (i < 7) return "R6";
        else            return "R7";
    endfunction

    task automatic check_all(input string tag);
        for (int i = 0; i < 8; i++)
            check((tag == "") ? tag_of(i) : tag, 32'(flag_o[i]), 32'(m_flag[i]));
    endtask

    // model of one strobe: pin_i is the value seen by the sampler
    task automatic model_strobe(input logic [7:0] kill);
        for (int i = 0; i < 8; i++) begin
            bit lvl, fall, rise, ev;
            lvl  = (i < 2) && !lvl_edge_sel_i[i];
            fall = m_primed && m_samp[i] && !pin_i[i];
            rise = m_primed && !m_samp[i] && pin_i[i];
            if (i < 2)      ev = fall;
            else if (i < 4) ev = pol_sel_i[i-2] ? rise : fall;
            else if (i < 7) ev = rise;
            else            ev = trig_en_i && fall;
            if (lvl)          m_flag[i] = !pin_i[i];
            else if (ev)      m_flag[i] = 1'b1;
            else if (kill[i]) m_flag[i] = 1'b0;
        end
        m_samp   = pin_i;
        m_primed = 1'b1;
    endtask

    // advance to just after the next strobe edge
    task automatic step(input logic [7:0] ack_m, input logic [7:0] clr_m);
        while (strobe_o !== 1'b1) @(negedge clk);
        ack_i    = ack_m;
        sw_clr_i = clr_m;
        @(negedge clk);
        ack_i    = 8'h00;
        sw_clr_i = 8'h00;
        model_strobe(ack_m | clr_m);
    endtask

    // one-clock clear outside a strobe
    task automatic kill(input logic [7:0] ack_m, input logic [7:0] clr_m);
        while (strobe_o !== 1'b0) @(negedge clk);
        ack_i    = ack_m;
        sw_clr_i = clr_m;
        @(negedge clk);
        ack_i    = 8'h00;
        sw_clr_i = 8'h00;
        m_flag   = m_flag & ~(ack_m | clr_m);
    endtask

    initial begin
        int k;
        repeat (3) @(negedge clk);
        check("R2", 32'(flag_o), 32'h0);
        check("R2", 32'(strobe_o), 32'h0);
        rst_n = 1'b1;

        k = 0;
        while (strobe_o !== 1'b1) begin @(negedge clk); k++; end
        check("R1", k, DIV - 1);
        @(negedge clk);
        model_strobe(8'h00);
        check("R11", 32'(flag_o), 32'h0);
        k = 0;
        do begin @(negedge clk); k++; end while (strobe_o !== 1'b1);
        check("R1", k, DIV - 1);
        @(negedge clk);
        model_strobe(8'h00);
        check_all("R11");

        // R6 / R8: rising edge, acknowledge, stays clear
        pin_i[4] = 1'b0; step(0, 0); check_all("");
        pin_i[4] = 1'b1; step(0, 0); check("R6", 32'(flag_o[4]), 32'h1);
        kill(8'h10, 0);               check("R8", 32'(flag_o[4]), 32'h0);
        step(0, 0);                   check("R8", 32'(flag_o[4]), 32'h0);

        // R9: set wins over same-cycle software clear, then plain clear
        pin_i[4] = 1'b0; step(0, 0);
        pin_i[4] = 1'b1; step(0, 8'h10); check("R9", 32'(flag_o[4]), 32'h1);
        kill(0, 8'h10);                  check("R9", 32'(flag_o[4]), 32'h0);

        // R10: pulses inside one machine cycle
        pin_i[4] = 1'b0; pin_i[7] = 1'b0;
        repeat (3) @(negedge clk);
        pin_i[4] = 1'b1; pin_i[7] = 1'b1;
        step(0, 0);
        check("R10", 32'(flag_o[4]), 32'h0);
        check("R10", 32'(flag_o[7]), 32'h0);

        // R7: gated falling edge
        trig_en_i = 1'b0; pin_i[7] = 1'b0; step(0, 0); check("R7", 32'(flag_o[7]), 32'h0);
        trig_en_i = 1'b1; pin_i[7] = 1'b1; step(0, 0);
        pin_i[7] = 1'b0; step(0, 0); check("R7", 32'(flag_o[7]), 32'h1);

        // R3: level tracking re-asserts after acknowledge
        lvl_edge_sel_i = 2'b10; pin_i[0] = 1'b0; step(0, 0); check("R3", 32'(flag_o[0]), 32'h1);
        kill(8'h01, 0);  check("R3", 32'(flag_o[0]), 32'h0);
        step(0, 0);      check("R3", 32'(flag_o[0]), 32'h1);
        pin_i[0] = 1'b1; step(0, 0); check("R3", 32'(flag_o[0]), 32'h0);

        // sweep of every mode combination
        for (int cfg = 0; cfg < 32; cfg++) begin
            lvl_edge_sel_i = cfg[1:0];
            pol_sel_i      = cfg[3:2];
            trig_en_i      = cfg[4];
            for (int s = 0; s < 10; s++) begin
                logic [7:0] am, cm;
                pin_i = 8'((s * 29 + cfg * 11) ^ (s * s * 3) ^ (cfg << (s % 4)));
                am = (s % 3 == 1) ? 8'(cfg * 7 + s) : 8'h00;
                cm = (s % 4 == 2) ? (8'hA5 ^ 8'(cfg)) : 8'h00;
                step(am, cm);
                check_all("");
                if (s % 2 == 0) begin
                    kill(8'(s * 13), 8'(cfg));
                    for (int i = 0; i < 8; i++)
                        check((i % 2 == 0) ? "R8" : "R9", 32'(flag_o[i]), 32'(m_flag[i]));
                end
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule